// File: doc/BRIEF.md
# Load/Store Lane Steering and Byte-Order Unit

This unit sits between a 32-bit register file and a 32-bit data memory port. A store or load request arrives with an access size (byte, halfword, fullword) and an address. For stores it moves the register data into the right byte lanes and drives one write enable per lane. For loads it takes the returned memory word, picks out the addressed lanes and sign-extends the value to 32 bits. Misaligned halfword or fullword requests, and requests with the reserved size code, raise an address error. Such a request never reaches memory.

The byte order is read from a pin on every clock edge while power-on reset is held low. It is frozen once reset is released. Big-endian order places the lowest-addressed byte in bits 31:24. Little-endian order places it in bits 7:0. The request path is a valid/ready stream that passes through to memory without storage. A legal request is offered to memory in the same cycle and is accepted when memory is ready, so memory back-pressure reaches the requester unchanged. A faulting request is consumed at once, with ready high, and is never forwarded. The load response path is a plain qualified bus with no back-pressure.

Top module: `lsu_lane_unit`

## Requirements
- R1: Size code 2'b00 is byte, 2'b01 is halfword and 2'b10 is fullword. Code 2'b11 is reserved, and a valid request that carries it asserts `addr_err`.
- R2: A valid byte request never asserts `addr_err`, whatever the address.
- R3: A valid halfword request with address bit 0 set, or a valid fullword request with either of address bits 1:0 set, asserts `addr_err` in the same cycle.
- R4: While `addr_err` is high, `mem_valid` is low, `mem_be` is 4'b0000 and `req_ready` is high, so the faulting request is dropped.
- R5: While `por_n` is low, every rising clock edge copies `endian_pin` into `big_endian` (1 = big-endian). While `por_n` is high, `big_endian` holds its value even if the pin toggles.
- R6: In little-endian order, a byte at offset o (the two low address bits) uses lane o, which is bits 8o+7:8o. A halfword at offset o uses lanes o and o+1, with its low byte in lane o.
- R7: In big-endian order, a byte at offset o uses lane 3-o. A halfword at offset 0 uses bits 31:16, and a halfword at offset 2 uses bits 15:0. A fullword uses all four lanes in both orders.
- R8: Store data is the byte repeated four times or the halfword repeated twice. `mem_be` enables exactly the addressed lanes, so it has 1, 2 or 4 bits set.
- R9: A byte or halfword load result is sign-extended from its top bit to 32 bits. A fullword load result equals the memory word.
- R10: For a legal request, `mem_valid` equals `req_valid` and `req_ready` equals `mem_ready`. `mem_addr` and `mem_we` pass through unchanged. `ld_valid` equals `rsp_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously |
| endian_pin | input | 1 | Byte-order strap: 1 for big-endian, 0 for little-endian |
| big_endian | output | 1 | Frozen byte order |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request consumed |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | Access size code |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| addr_err | output | 1 | Misaligned or reserved-size request |
| mem_valid | output | 1 | Memory request strobe |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory byte address |
| mem_be | output | 4 | Lane write/read enables |
| mem_wdata | output | 32 | Lane-steered store data |
| rsp_valid | input | 1 | Memory read data valid |
| rsp_size | input | 2 | Size code of the returning load |
| rsp_off | input | 2 | Low address bits of the returning load |
| rsp_rdata | input | 32 | Memory read word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Two functions can act in the same cycle: the alignment check, and the lane steering together with the handshake. A misaligned request is driven while memory is ready and while it is stalled. In both cases the bench checks that the error wins: the strobe and all lane enables stay low, and ready is still high even though memory is stalled. The frozen byte order also meets lane steering. The strap is flipped after reset and a store is issued in the same cycle. Its lane enables must still follow the order captured during reset.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_FULL = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // number of bytes covered by a size code; reserved maps to a full word
  function automatic logic [2:0] size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // lane index of the least significant byte of the access
  function automatic logic [OFF_W-1:0] lane_base(logic big, acc_size_e s,
                                                 logic [OFF_W-1:0] off);
    logic [2:0] tmp;
    tmp = 3'd4 - size_bytes(s) - {1'b0, off};
    lane_base = big ? tmp[OFF_W-1:0] : off;
  endfunction
endpackage

// File: rtl/lsu_endian_latch.sv
module lsu_endian_latch (
  input  logic clk_i,
  input  logic por_ni,
  input  logic pin_i,
  output logic big_o
);
  logic big_q;

  always_ff @(posedge clk_i) begin
    if (!por_ni) big_q <= pin_i;
  end

  assign big_o = big_q;

  assert_order_locked_R5: assert property (@(posedge clk_i) disable iff (!por_ni)
    $past(por_ni) |-> $stable(big_q))
    else $error("byte order changed after reset");
endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_pkg::*;
(
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             valid_i,
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             err_o
);
  logic misal;

  always_comb begin
    case (size_i)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = off_i[0];
      SZ_FULL: misal = |off_i;
      default: misal = 1'b1;
    endcase
  end

  assign err_o = valid_i & misal;

  assert_byte_legal_R2: assert property (@(posedge clk_i) disable iff (!por_ni)
    (valid_i && size_i == SZ_BYTE) |-> !err_o)
    else $error("byte access flagged");

  assert_rsvd_flags_R1: assert property (@(posedge clk_i) disable iff (!por_ni)
    (valid_i && size_i == SZ_RSVD) |-> err_o)
    else $error("reserved size not flagged");
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              en_i,
  input  logic              big_i,
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [LANES-1:0] base_mask;
  logic [OFF_W-1:0] sh;

  assign sh = lane_base(big_i, size_i, off_i);

  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        base_mask = 4'b0001;
        wdata_o   = {4{wdata_i[7:0]}};
      end
      SZ_HALF: begin
        base_mask = 4'b0011;
        wdata_o   = {2{wdata_i[15:0]}};
      end
      SZ_FULL: begin
        base_mask = 4'b1111;
        wdata_o   = wdata_i;
      end
      default: begin
        base_mask = 4'b0000;
        wdata_o   = wdata_i;
      end
    endcase
  end

  assign be_o = en_i ? LANES'(base_mask << sh) : '0;

  assert_lane_count_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
    en_i |-> ($countones(be_o) == int'(size_bytes(size_i))))
    else $error("wrong number of lanes enabled");
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              valid_i,
  input  logic              big_i,
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic [OFF_W-1:0]  sh;
  logic [DATA_W-1:0] shifted;

  assign sh      = lane_base(big_i, size_i, off_i);
  assign shifted = rdata_i >> {sh, 3'b000};

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {{24{shifted[7]}}, shifted[7:0]};
      SZ_HALF: data_o = {{16{shifted[15]}}, shifted[15:0]};
      default: data_o = rdata_i;
    endcase
  end

  assert_full_passthru_R9: assert property (@(posedge clk_i) disable iff (!por_ni)
    (valid_i && size_i == SZ_FULL) |-> data_o == rdata_i)
    else $error("fullword load altered");

  assert_half_source_R7: assert property (@(posedge clk_i) disable iff (!por_ni)
    (valid_i && size_i == SZ_HALF) |->
      (data_o[15:0] == rdata_i[15:0] || data_o[15:0] == rdata_i[31:16]))
    else $error("halfword not taken from a half");
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          endian_pin,
  output logic          big_endian,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          addr_err,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          rsp_valid,
  input  logic [1:0]    rsp_size,
  input  logic [1:0]    rsp_off,
  input  logic [31:0]   rsp_rdata,
  output logic          ld_valid,
  output logic [31:0]   ld_data
);
  acc_size_e        req_sz, rsp_sz;
  logic [OFF_W-1:0] req_off;
  logic             legal;

  assign req_sz  = acc_size_e'(req_size);
  assign rsp_sz  = acc_size_e'(rsp_size);
  assign req_off = req_addr[OFF_W-1:0];

  lsu_endian_latch u_order (
    .clk_i (clk),
    .por_ni(por_n),
    .pin_i (endian_pin),
    .big_o (big_endian)
  );

  lsu_align_check u_align (
    .clk_i  (clk),
    .por_ni (por_n),
    .valid_i(req_valid),
    .size_i (req_sz),
    .off_i  (req_off),
    .err_o  (addr_err)
  );

  assign legal     = req_valid & ~addr_err;
  assign mem_valid = legal;
  assign req_ready = addr_err | mem_ready;
  assign mem_we    = req_write;
  assign mem_addr  = req_addr;

  lsu_store_steer u_store (
    .clk_i  (clk),
    .por_ni (por_n),
    .en_i   (legal),
    .big_i  (big_endian),
    .size_i (req_sz),
    .off_i  (req_off),
    .wdata_i(req_wdata),
    .be_o   (mem_be),
    .wdata_o(mem_wdata)
  );

  lsu_load_extract u_load (
    .clk_i  (clk),
    .por_ni (por_n),
    .valid_i(rsp_valid),
    .big_i  (big_endian),
    .size_i (rsp_sz),
    .off_i  (rsp_off),
    .rdata_i(rsp_rdata),
    .data_o (ld_data)
  );

  assign ld_valid = rsp_valid;

  assert_err_drops_R4: assert property (@(posedge clk) disable iff (!por_n)
    addr_err |-> (!mem_valid && mem_be == 4'b0000 && req_ready))
    else $error("faulting request reached memory");

  assert_strobe_needs_req_R10: assert property (@(posedge clk) disable iff (!por_n)
    mem_valid |-> (req_valid && req_ready == mem_ready))
    else $error("strobe without request");

  assert_misaligned_R3: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid && ((req_sz == SZ_HALF && req_addr[0]) ||
                   (req_sz == SZ_FULL && req_addr[1:0] != 2'b00))) |-> !mem_valid)
    else $error("misaligned request forwarded");
endmodule

// File: tb/test_lsu_lane_unit.sv
module test_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        por_n, endian_pin, big_endian;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        addr_err, mem_valid, mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        rsp_valid;
  logic [1:0]  rsp_size, rsp_off;
  logic [31:0] rsp_rdata, ld_data;
  logic        ld_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  lsu_lane_unit #(.AW(32)) i_lsu_lane_unit (
    .clk(clk), .por_n(por_n), .endian_pin(endian_pin), .big_endian(big_endian),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .addr_err(addr_err), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_size(rsp_size), .rsp_off(rsp_off),
    .rsp_rdata(rsp_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reset_with(logic pin);
    @(negedge clk);
    por_n = 1'b0; endian_pin = pin;
    req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    mem_ready = 1; rsp_valid = 0; rsp_size = 0; rsp_off = 0; rsp_rdata = 0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R5 captured order", {31'd0, big_endian}, {31'd0, pin});
    check("R10 idle no strobe", {31'd0, mem_valid}, 32'd0);
  endtask

  task automatic drive(logic wr, logic [1:0] sz, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    #1;
  endtask

  task automatic t_lock;
    // strap flips after reset; a store issued in the same cycle keeps the old order
    logic held;
    held = big_endian;
    @(negedge clk);
    endian_pin = ~endian_pin;
    req_valid = 1; req_write = 1; req_size = 2'b00; req_addr = 32'h10; req_wdata = 32'hAB;
    #1;
    check("R5 lane under flipped strap", {28'd0, mem_be}, held ? 32'h8 : 32'h1);
    repeat (3) @(negedge clk);
    check("R5 order held", {31'd0, big_endian}, {31'd0, held});
    req_valid = 0;
  endtask

  task automatic t_store_lanes(logic big);
    for (int o = 0; o < 4; o++) begin
      drive(1, 2'b00, 32'h100 + o, 32'h0000_005A);
      check(big ? "R7 byte lane" : "R6 byte lane", {28'd0, mem_be},
            big ? (32'h8 >> o) : (32'h1 << o));
      check("R8 byte replicate", mem_wdata, 32'h5A5A_5A5A);
      check("R2 byte no error", {31'd0, addr_err}, 32'd0);
    end
    for (int o = 0; o < 4; o += 2) begin
      drive(1, 2'b01, 32'h200 + o, 32'h0000_C3D4);
      check(big ? "R7 half lanes" : "R6 half lanes", {28'd0, mem_be},
            big ? (32'hC >> o) : (32'h3 << o));
      check("R8 half replicate", mem_wdata, 32'hC3D4_C3D4);
    end
    drive(1, 2'b10, 32'h300, 32'h1234_5678);
    check("R7 full lanes", {28'd0, mem_be}, 32'hF);
    check("R8 full data", mem_wdata, 32'h1234_5678);
    check("R10 addr pass", mem_addr, 32'h300);
    check("R10 we pass", {31'd0, mem_we}, 32'd1);
    req_valid = 0;
  endtask

  task automatic t_loads(logic big);
    logic [31:0] eb [4];
    if (big) begin
      eb[0] = 32'hFFFF_FF80; eb[1] = 32'h0000_007F; eb[2] = 32'hFFFF_FFF0; eb[3] = 32'h1;
    end else begin
      eb[0] = 32'h1; eb[1] = 32'hFFFF_FFF0; eb[2] = 32'h0000_007F; eb[3] = 32'hFFFF_FF80;
    end
    for (int o = 0; o < 4; o++) begin
      @(negedge clk);
      rsp_valid = 1; rsp_rdata = 32'h807F_F001; rsp_size = 2'b00; rsp_off = 2'(o);
      #1;
      check("R9 byte sign extend", ld_data, eb[o]);
      check("R10 ld_valid", {31'd0, ld_valid}, 32'd1);
    end
    @(negedge clk); rsp_size = 2'b01; rsp_off = 2'd0; #1;
    check("R9 half off0", ld_data, big ? 32'hFFFF_807F : 32'hFFFF_F001);
    @(negedge clk); rsp_off = 2'd2; #1;
    check("R9 half off2", ld_data, big ? 32'hFFFF_F001 : 32'hFFFF_807F);
    @(negedge clk); rsp_size = 2'b10; rsp_off = 2'd0; #1;
    check("R9 full", ld_data, 32'h807F_F001);
    @(negedge clk); rsp_size = 2'b00; rsp_rdata = 32'h0000_0000; #1;
    check("R9 zero byte", ld_data, 32'd0);
    rsp_valid = 0;
  endtask

  task automatic t_errors;
    for (int st = 0; st < 2; st++) begin
      mem_ready = (st == 0);
      drive(1, 2'b01, 32'h401, 32'hFFFF);
      check("R3 half odd", {31'd0, addr_err}, 32'd1);
      check("R4 no strobe", {31'd0, mem_valid}, 32'd0);
      check("R4 be zero", {28'd0, mem_be}, 32'd0);
      check("R4 ready while stalled", {31'd0, req_ready}, 32'd1);
      drive(0, 2'b10, 32'h402, 32'h0);
      check("R3 full off2", {31'd0, addr_err}, 32'd1);
      drive(0, 2'b11, 32'h400, 32'h0);
      check("R1 reserved size", {31'd0, addr_err}, 32'd1);
      check("R4 reserved no strobe", {31'd0, mem_valid}, 32'd0);
      drive(0, 2'b10, 32'h404, 32'h0);
      check("R3 aligned full ok", {31'd0, addr_err}, 32'd0);
      check("R10 strobe", {31'd0, mem_valid}, 32'd1);
      check("R10 ready follows mem", {31'd0, req_ready}, {31'd0, mem_ready});
    end
    mem_ready = 1;
    req_valid = 0;
    #1;
    check("R10 no strobe without request", {31'd0, mem_valid}, 32'd0);
  endtask

  initial begin
    reset_with(1'b1);
    t_store_lanes(1'b1);
    t_loads(1'b1);
    t_lock;
    t_errors;
    reset_with(1'b0);
    t_store_lanes(1'b0);
    t_loads(1'b0);
    t_lock;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule